// File: doc/BRIEF.md
# Synthesizer Divider Parameter Calculator

This block turns a requested synthesizer output frequency into the two divider settings that a clock synthesizer running from a 16 MHz reference needs: a 9-bit feedback divider value M and a 2-bit output divider code. With that reference the synthesized frequency is 2·M/D MHz, where D is the output divide ratio of 1, 2, 4 or 8. The request is given in 250 kHz units (quarter-MHz), so a request value q stands for q/4 MHz, and it is accepted on a one-cycle start strobe.

The block picks the output divide ratio from the band the request falls in, scales the request into M, confirms that M lies in the legal loop range of 200 to 400, and registers the result. Requests outside 50 to 800 MHz, and requests that fall between the steps the chosen band can reach, are reported as errors. An error leaves the last good M and code unchanged. Requests may be issued on every cycle. The result comes out two cycles later with a one-cycle completion pulse.

Top module: `synth_div_calc`

## Requirements
- R1: A legal request q (quarter-MHz units) selects divide ratio 1 when q >= 1600, ratio 2 when 800 <= q < 1600, ratio 4 when 400 <= q < 800 and ratio 8 when 200 <= q < 400. The output code for each ratio is 2'b11 for ratio 1, 2'b00 for ratio 2, 2'b01 for ratio 4 and 2'b10 for ratio 8.
- R2: For a legal, exact request, m_div equals q·D/8, which makes 2·m_div/D equal to the requested frequency. A 131 MHz request (q = 524) gives code 2'b01 and m_div = 262.
- R3: A request on a frequency shared by two bands (100, 200 or 400 MHz) takes the smaller divide ratio, so it gives m_div = 200. For 400 MHz this means code 2'b11.
- R4: A request below 200 or above 3200 (below 50 MHz or above 800 MHz) sets err_range and clears valid. m_div and n_code keep their previous values.
- R5: A legal request for which q·D/8 is not an integer sets err_inexact and clears valid. This happens when the low 3, 2 or 1 bits of q are not zero for ratio 1, 2 or 4 respectively. m_div and n_code keep their previous values.
- R6: Whenever valid is high, m_div lies between 200 and 400 inclusive.
- R7: done is high for exactly the cycle that comes two cycles after a cycle in which start was high. Starts on consecutive cycles give done on consecutive cycles, each with its own result.
- R8: m_div, n_code, valid, err_range and err_inexact change only in a cycle in which done is high.
- R9: After reset, done, valid, err_range and err_inexact are 0, m_div is 0 and n_code is 2'b00.
- R10: In every done cycle exactly one of valid, err_range and err_inexact is high. err_range takes precedence over err_inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe; freq_q is sampled when high |
| freq_q | input | 12 | Requested frequency in 250 kHz units |
| done | output | 1 | One-cycle pulse, two cycles after start |
| valid | output | 1 | Last result was legal and exact |
| err_range | output | 1 | Last request was outside 50–800 MHz |
| err_inexact | output | 1 | Last request was not reachable in its band |
| m_div | output | 9 | Feedback divider value M |
| n_code | output | 2 | Output divider code |

## Verification
A wrong band choice or a wrong stage-one register shows up two cycles after the start, in the done cycle. It appears as a wrong n_code together with an m_div that is off by a power of two, or as a flag that is wrongly raised. A fault in the hold path only shows when an erroring request follows a good one: the earlier M and code change in the same done cycle and stay wrong until the next good request. Loss of the done pulse or a shift in its timing is seen at the port on the second cycle after the strobe.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  // Band index: output divide ratio is 2**index.
  typedef enum logic [1:0] {
    BAND_D1 = 2'd0,
    BAND_D2 = 2'd1,
    BAND_D4 = 2'd2,
    BAND_D8 = 2'd3
  } band_e;

  // Output divider code for a band (the code order is not monotonic).
  function automatic logic [1:0] band_code(band_e b);
    case (b)
      BAND_D1: return 2'b11;
      BAND_D2: return 2'b00;
      BAND_D4: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  // Right shift that turns a quarter-MHz request into M for a band.
  function automatic logic [1:0] band_shift(band_e b);
    return 2'd3 - b;
  endfunction

  // Request bits that the shift discards; any set bit means inexact.
  function automatic logic [2:0] band_drop_mask(band_e b);
    case (b)
      BAND_D1: return 3'b111;
      BAND_D2: return 3'b011;
      BAND_D4: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/synth_band_pick.sv
module synth_band_pick
  import synth_div_pkg::*;
#(
  parameter int unsigned REQ_W = 12,
  parameter int unsigned M_MIN = 200,
  parameter int unsigned M_MAX = 400
) (
  input  logic [REQ_W-1:0] req,
  output band_e            band,
  output logic             range_bad
);

  localparam int unsigned NBANDS  = 4;
  localparam int unsigned REQ_LO  = M_MIN;
  localparam int unsigned REQ_HI  = M_MAX << (NBANDS - 1);

  logic [NBANDS-1:0] hit;

  // hit[k]: request reaches the lower edge of band k.
  for (genvar k = 0; k < NBANDS; k++) begin : g_edge
    localparam int unsigned EDGE = M_MIN << (NBANDS - 1 - k);
    assign hit[k] = (req >= REQ_W'(EDGE));
  end

  // Smallest divide ratio whose edge is reached wins (shared edges too).
  always_comb begin
    band = BAND_D8;
    for (int k = NBANDS - 1; k >= 0; k--) begin
      if (hit[k]) band = band_e'(2'(k));
    end
  end

  assign range_bad = (req < REQ_W'(REQ_LO)) || (req > REQ_W'(REQ_HI));

endmodule

// File: rtl/synth_m_scale.sv
module synth_m_scale
  import synth_div_pkg::*;
#(
  parameter int unsigned REQ_W = 12,
  parameter int unsigned M_W   = 9,
  parameter int unsigned M_MIN = 200,
  parameter int unsigned M_MAX = 400
) (
  input  logic [REQ_W-1:0] req,
  input  band_e            band,
  output logic [M_W-1:0]   m_val,
  output logic             inexact,
  output logic             lock_ok
);

  logic [REQ_W-1:0] m_wide;

  assign m_wide  = req >> band_shift(band);
  assign inexact = |(req[2:0] & band_drop_mask(band));
  assign lock_ok = (m_wide >= REQ_W'(M_MIN)) && (m_wide <= REQ_W'(M_MAX));
  assign m_val   = M_W'(m_wide);

endmodule

// File: rtl/synth_result_reg.sv
module synth_result_reg #(
  parameter int unsigned M_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  logic           range_bad,
  input  logic           inexact,
  input  logic           lock_ok,
  input  logic [M_W-1:0] m_in,
  input  logic [1:0]     code_in,
  output logic           done,
  output logic           valid,
  output logic           err_range,
  output logic           err_inexact,
  output logic [M_W-1:0] m_div,
  output logic [1:0]     n_code
);

  logic good;
  logic rng_n;
  logic frac_n;

  // Priority: range, then exactness, then loop range.
  always_comb begin
    rng_n  = 1'b0;
    frac_n = 1'b0;
    good   = 1'b0;
    if (range_bad)     rng_n  = 1'b1;
    else if (inexact)  frac_n = 1'b1;
    else if (!lock_ok) rng_n  = 1'b1;
    else               good   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      valid       <= 1'b0;
      err_range   <= 1'b0;
      err_inexact <= 1'b0;
      m_div       <= '0;
      n_code      <= 2'b00;
    end else begin
      done <= fire;
      if (fire) begin
        valid       <= good;
        err_range   <= rng_n;
        err_inexact <= frac_n;
        if (good) begin
          m_div  <= m_in;
          n_code <= code_in;
        end
      end
    end
  end

endmodule

// File: rtl/synth_div_calc.sv
module synth_div_calc
  import synth_div_pkg::*;
#(
  parameter int unsigned REQ_W = 12,
  parameter int unsigned M_W   = 9,
  parameter int unsigned M_MIN = 200,
  parameter int unsigned M_MAX = 400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [REQ_W-1:0] freq_q,
  output logic             done,
  output logic             valid,
  output logic             err_range,
  output logic             err_inexact,
  output logic [M_W-1:0]   m_div,
  output logic [1:0]       n_code
);

  // Stage 0 -> 1: band choice and range test on the raw request.
  band_e            pick_band;
  logic             pick_range_bad;

  // Stage 1 registers.
  logic             s1_vld;
  logic [REQ_W-1:0] s1_req;
  band_e            s1_band;
  logic             s1_range_bad;

  // Named internal events for the checker.
  logic             evt_inexact;
  logic             evt_lock_ok;
  logic [M_W-1:0]   s1_m;

  synth_band_pick #(
    .REQ_W(REQ_W), .M_MIN(M_MIN), .M_MAX(M_MAX)
  ) u_pick (
    .req      (freq_q),
    .band     (pick_band),
    .range_bad(pick_range_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld       <= 1'b0;
      s1_req       <= '0;
      s1_band      <= BAND_D8;
      s1_range_bad <= 1'b0;
    end else begin
      s1_vld <= start;
      if (start) begin
        s1_req       <= freq_q;
        s1_band      <= pick_band;
        s1_range_bad <= pick_range_bad;
      end
    end
  end

  synth_m_scale #(
    .REQ_W(REQ_W), .M_W(M_W), .M_MIN(M_MIN), .M_MAX(M_MAX)
  ) u_scale (
    .req    (s1_req),
    .band   (s1_band),
    .m_val  (s1_m),
    .inexact(evt_inexact),
    .lock_ok(evt_lock_ok)
  );

  synth_result_reg #(.M_W(M_W)) u_res (
    .clk        (clk),
    .rst        (rst),
    .fire       (s1_vld),
    .range_bad  (s1_range_bad),
    .inexact    (evt_inexact),
    .lock_ok    (evt_lock_ok),
    .m_in       (s1_m),
    .code_in    (band_code(s1_band)),
    .done       (done),
    .valid      (valid),
    .err_range  (err_range),
    .err_inexact(err_inexact),
    .m_div      (m_div),
    .n_code     (n_code)
  );

endmodule

// File: rtl/synth_div_calc_chk.sv
module synth_div_calc_chk #(
  parameter int unsigned M_W   = 9,
  parameter int unsigned M_MIN = 200,
  parameter int unsigned M_MAX = 400
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           done,
  input logic           valid,
  input logic           err_range,
  input logic           err_inexact,
  input logic [M_W-1:0] m_div,
  input logic [1:0]     n_code,
  input logic           evt_lock_ok
);

  // Edges seen since reset released, saturating.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R7: done follows start by exactly two cycles.
  a_r7_done_timing: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (done == $past(start, 2)));

  // R6: valid result stays inside the loop range.
  a_r6_m_in_loop: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((m_div >= M_W'(M_MIN)) && (m_div <= M_W'(M_MAX))));

  // R6: a valid completion came from a scale result that passed the loop test.
  a_r6_lock_event: assert property (@(posedge clk) disable iff (rst)
    (done && valid && age >= 2'd1) |-> $past(evt_lock_ok));

  // R8: results move only with done.
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!done && age >= 2'd1) |-> ($stable(m_div) && $stable(n_code) &&
                                $stable(valid) && $stable(err_range) &&
                                $stable(err_inexact)));

  // R4/R5: an erroring completion leaves M and code untouched.
  a_r4_r5_hold_on_error: assert property (@(posedge clk) disable iff (rst)
    (done && !valid && age >= 2'd1) |-> ($stable(m_div) && $stable(n_code)));

  // R10: exactly one outcome flag per completion.
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones({valid, err_range, err_inexact}) == 1));

  // R10: never more than one outcome flag.
  a_r10_flags_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({valid, err_range, err_inexact}));

endmodule

bind synth_div_calc synth_div_calc_chk #(
  .M_W(M_W), .M_MIN(M_MIN), .M_MAX(M_MAX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .done       (done),
  .valid      (valid),
  .err_range  (err_range),
  .err_inexact(err_inexact),
  .m_div      (m_div),
  .n_code     (n_code),
  .evt_lock_ok(evt_lock_ok)
);

// File: tb/synth_div_calc_test.sv
`timescale 1ns/1ps
module synth_div_calc_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [11:0] freq_q;
  logic        done, valid, err_range, err_inexact;
  logic [8:0]  m_div;
  logic [1:0]  n_code;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Expected held state.
  int exp_m    = 0;
  int exp_code = 0;

  always #5 clk = ~clk;

  synth_div_calc uut (
    .clk(clk), .rst(rst), .start(start), .freq_q(freq_q),
    .done(done), .valid(valid), .err_range(err_range),
    .err_inexact(err_inexact), .m_div(m_div), .n_code(n_code)
  );

  task automatic check(string req_tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  // Outcome kinds: 0 valid, 1 range error, 2 inexact.
  typedef struct {
    int kind;
    int m;
    int code;
  } exp_t;

  // Independent model: frequency in MHz·4, ratio from MHz thresholds.
  function automatic exp_t model(int q);
    exp_t e;
    int ratio;
    int prod;
    e.m = 0; e.code = 0;
    if (q * 1 < 50 * 4 || q > 800 * 4) begin
      e.kind = 1;
      return e;
    end
    if (q >= 400 * 4)      begin ratio = 1; e.code = 3; end
    else if (q >= 200 * 4) begin ratio = 2; e.code = 0; end
    else if (q >= 100 * 4) begin ratio = 4; e.code = 1; end
    else                   begin ratio = 8; e.code = 2; end
    prod = q * ratio;
    if (prod % 8 != 0) begin
      e.kind = 2;
      return e;
    end
    e.m = prod / 8;
    e.kind = (e.m >= 200 && e.m <= 400) ? 0 : 1;
    return e;
  endfunction

  task automatic expect_result(string tag, int q);
    exp_t e = model(q);
    if (e.kind == 0) begin
      exp_m = e.m;
      exp_code = e.code;
    end
    check(tag, "done", int'(done), 1);
    check(tag, "valid", int'(valid), (e.kind == 0) ? 1 : 0);
    check(tag, "err_range", int'(err_range), (e.kind == 1) ? 1 : 0);
    check(tag, "err_inexact", int'(err_inexact), (e.kind == 2) ? 1 : 0);
    check(tag, "m_div", int'(m_div), exp_m);
    check(tag, "n_code", int'(n_code), exp_code);
  endtask

  // One request; done is sampled in the second cycle after the strobe.
  task automatic apply(string tag, int q);
    @(negedge clk);
    freq_q = 12'(q);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    check("R7", "done early", int'(done), 0);
    @(negedge clk);
    expect_result(tag, q);
    @(negedge clk);
    check("R7", "done width", int'(done), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; freq_q = '0;
    repeat (3) @(negedge clk);
    check("R9", "done", int'(done), 0);
    check("R9", "valid", int'(valid), 0);
    check("R9", "err_range", int'(err_range), 0);
    check("R9", "err_inexact", int'(err_inexact), 0);
    check("R9", "m_div", int'(m_div), 0);
    check("R9", "n_code", int'(n_code), 0);
    rst = 1'b0;
  endtask

  task automatic t_bands();
    apply("R2", 524);   // 131 MHz -> code 01, M 262
    check("R2", "m 131MHz", int'(m_div), 262);
    check("R1", "code 131MHz", int'(n_code), 1);
    apply("R1", 2400);  // 600 MHz, ratio 1
    apply("R1", 1000);  // 250 MHz, ratio 2
    apply("R1", 300);   // 75 MHz, ratio 8
    apply("R2", 301);   // 75.25 MHz, ratio 8
    apply("R2", 3200);  // 800 MHz top
    apply("R2", 200);   // 50 MHz bottom
  endtask

  task automatic t_edges();
    apply("R3", 1600);  // 400 MHz
    check("R3", "code 400MHz", int'(n_code), 3);
    check("R3", "m 400MHz", int'(m_div), 200);
    apply("R3", 800);   // 200 MHz
    check("R3", "code 200MHz", int'(n_code), 0);
    apply("R3", 400);   // 100 MHz
    check("R3", "code 100MHz", int'(n_code), 1);
  endtask

  task automatic t_range();
    apply("R6", 2000);  // known good first
    apply("R4", 199);
    apply("R4", 3201);
    apply("R4", 0);
    apply("R4", 4095);
  endtask

  task automatic t_inexact();
    apply("R5", 1601);  // ratio 1, low bits 001
    apply("R5", 1604);  // ratio 1, low bits 100
    apply("R5", 802);   // ratio 2
    apply("R5", 401);   // ratio 4
    apply("R5", 1599);  // ratio 2, just below edge
  endtask

  task automatic t_back_to_back();
    @(negedge clk); freq_q = 12'd2048; start = 1'b1;
    @(negedge clk); freq_q = 12'd100;
    @(negedge clk); freq_q = 12'd612;
    expect_result("R7", 2048);
    @(negedge clk); start = 1'b0;
    expect_result("R7", 100);
    @(negedge clk);
    expect_result("R7", 612);
    @(negedge clk);
    check("R7", "done after burst", int'(done), 0);
  endtask

  task automatic t_hold();
    apply("R8", 720);
    freq_q = 12'd3000;  // changes on the input without a strobe
    repeat (5) begin
      @(negedge clk);
      check("R8", "done idle", int'(done), 0);
      check("R8", "m idle", int'(m_div), exp_m);
      check("R8", "code idle", int'(n_code), exp_code);
      check("R8", "valid idle", int'(valid), 1);
    end
  endtask

  initial begin
    t_reset();
    t_bands();
    t_edges();
    t_range();
    t_inexact();
    t_back_to_back();
    t_hold();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule